// File: doc/BRIEF.md
# Multistage-Network Prefix Scan Unit

This block takes a vector of N lanes, each W bits wide, and returns all N inclusive running combinations of those lanes under one associative operator chosen at elaboration. Lane i of the result holds the combination of input lanes 0 through i, with the lower lane always the left operand.

The work is done by log_R(N) registered stages of R-by-R combining switches wired as an omega-style multistage network. Values only travel toward higher-numbered lanes. At every switch, the partial results from lower sub-blocks are merged with the exclusive partial result each lane already holds. After the last stage, every lane holds the combination of all lanes below it. One final local combine with the lane's own input gives the inclusive value. The identity of every supported operator is zero, and lane 0 gets that identity as its exclusive value.

The unit is fully pipelined. It takes one vector per clock, and a valid bit travels beside the data so that the result strobe marks exactly the cycle in which all N lanes are correct. The reset input is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `psc_scan_top`

## Requirements
- R1: When `out_valid` is high, lane i of `out_data` (bits i*W+W-1 down to i*W) equals lane0 op lane1 op ... op lane i of the accepted input vector, combined left to right in lane order.
- R2: Lane 0 of the result equals input lane 0 unchanged, because its exclusive value is the operator identity, which is zero for every supported operator.
- R3: Parameter `OP` selects the operator: `PSC_ADD` (0) is addition, `PSC_MAX` (1) is the unsigned maximum, `PSC_OR` (2) is bitwise OR, and `PSC_XOR` (3) is bitwise XOR.
- R4: Addition wraps modulo 2^W with no saturation. For example, with W=8 and all lanes 8'hFF, lane 1 gives 8'hFE and lane 7 gives 8'hF8.
- R5: `out_valid` is high after the (log_R(N)+2)-th rising edge, counting the edge that samples `in_valid` high as the first, and it stays high for exactly one cycle for each accepted vector.
- R6: A vector can be accepted on every clock. Back-to-back vectors produce results on consecutive cycles, in the same order.
- R7: While `in_valid` is low, `in_data` has no effect. `out_data` keeps its last value in every cycle in which no new result is produced.
- R8: While `rst_n` is low, `out_valid` and `out_data` are zero. A vector that is in flight when reset is asserted produces no result.
- R9: Changing only the highest input lane leaves lanes 0 to N-2 of the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept `in_data` on this edge |
| in_data | input | N*W | Input lanes, lane 0 in the low bits |
| out_valid | output | 1 | One-cycle strobe: all result lanes valid |
| out_data | output | N*W | Inclusive prefix per lane, lane 0 in the low bits |

## Verification
A table of fixed vectors is run through four copies of the block at once, one per operator. The table includes all-zero and all-ones inputs, an ascending ramp, single-bit-per-lane patterns, alternating full and empty bytes, and irregular mixes. Each result is compared with a sequential left-to-right scan. All-ones separates wrapping addition from saturating addition. The ramp and the single-bit patterns reveal a lane that picks up a contribution from the wrong sub-block or misses one from the right one. The alternating bytes separate OR from XOR and expose a maximum that looks only at nearby lanes. Directed cases then cover back-to-back vectors, a vector that differs only in its top lane, input noise while `in_valid` is low, and a reset in the middle of a flight.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [1:0] {
    PSC_ADD = 2'd0,
    PSC_MAX = 2'd1,
    PSC_OR  = 2'd2,
    PSC_XOR = 2'd3
  } psc_op_e;

  // Number of radix-r stages needed to span n lanes.
  function automatic int psc_stages(input int n, input int r);
    int span;
    int cnt;
    span = 1;
    cnt  = 0;
    while (span < n) begin
      span = span * r;
      cnt  = cnt + 1;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/psc_op.sv
module psc_op #(
  parameter int              W  = 8,
  parameter psc_pkg::psc_op_e OP = psc_pkg::PSC_ADD
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import psc_pkg::*;

  // a is always the lower-index operand
  generate
    if (OP == PSC_ADD) begin : g_add
      assign y = a + b;
    end else if (OP == PSC_MAX) begin : g_max
      assign y = (a > b) ? a : b;
    end else if (OP == PSC_OR) begin : g_or
      assign y = a | b;
    end else begin : g_xor
      assign y = a ^ b;
    end
  endgenerate

endmodule

// File: rtl/psc_switch.sv
module psc_switch #(
  parameter int              W  = 8,
  parameter int              R  = 2,
  parameter psc_pkg::psc_op_e OP = psc_pkg::PSC_ADD
) (
  input  logic [R-1:0][W-1:0] excl_i,
  input  logic [R-1:0][W-1:0] tot_i,
  output logic [R-1:0][W-1:0] excl_o,
  output logic [W-1:0]        tot_o
);
  // run[d] = combination of sub-block totals 0..d-1 (identity for d=0)
  logic [R:0][W-1:0] run;

  assign run[0] = '0;

  genvar d;
  generate
    for (d = 0; d < R; d++) begin : g_port
      psc_op #(.W(W), .OP(OP)) u_run (
        .a(run[d]),
        .b(tot_i[d]),
        .y(run[d+1])
      );
      psc_op #(.W(W), .OP(OP)) u_merge (
        .a(run[d]),
        .b(excl_i[d]),
        .y(excl_o[d])
      );
    end
  endgenerate

  assign tot_o = run[R];

endmodule

// File: rtl/psc_stage.sv
module psc_stage #(
  parameter int              W     = 8,
  parameter int              N     = 8,
  parameter int              R     = 2,
  parameter int              S_IDX = 0,
  parameter psc_pkg::psc_op_e OP    = psc_pkg::PSC_ADD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld_i,
  input  logic [N-1:0][W-1:0] excl_i,
  input  logic [N-1:0][W-1:0] tot_i,
  input  logic [N-1:0][W-1:0] own_i,
  output logic                vld_o,
  output logic [N-1:0][W-1:0] excl_o,
  output logic [N-1:0][W-1:0] tot_o,
  output logic [N-1:0][W-1:0] own_o
);
  localparam int BLK  = R ** S_IDX;   // sub-block size entering this stage
  localparam int NSW  = N / R;        // switches per stage

  logic [N-1:0][W-1:0] excl_n;
  logic [N-1:0][W-1:0] tot_n;

  genvar k, d;
  generate
    for (k = 0; k < NSW; k++) begin : g_sw
      localparam int GRP  = k / BLK;
      localparam int POS  = k % BLK;
      localparam int BASE = GRP * BLK * R + POS;

      logic [R-1:0][W-1:0] sw_excl_i;
      logic [R-1:0][W-1:0] sw_tot_i;
      logic [R-1:0][W-1:0] sw_excl_o;
      logic [W-1:0]        sw_tot_o;

      for (d = 0; d < R; d++) begin : g_wire
        assign sw_excl_i[d]           = excl_i[BASE + d*BLK];
        assign sw_tot_i[d]            = tot_i[BASE + d*BLK];
        assign excl_n[BASE + d*BLK]   = sw_excl_o[d];
        assign tot_n[BASE + d*BLK]    = sw_tot_o;
      end

      psc_switch #(.W(W), .R(R), .OP(OP)) u_sw (
        .excl_i(sw_excl_i),
        .tot_i (sw_tot_i),
        .excl_o(sw_excl_o),
        .tot_o (sw_tot_o)
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      excl_o <= '0;
      tot_o  <= '0;
      own_o  <= '0;
    end else if (vld_i) begin
      excl_o <= excl_n;
      tot_o  <= tot_n;
      own_o  <= own_i;
    end
  end

  // Data registers only move with a travelling valid (R7)
  p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(excl_o) && $stable(tot_o) && $stable(own_o)));

  // Valid advances exactly one stage per clock (R5)
  p_stage_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);

endmodule

// File: rtl/psc_scan_top.sv
module psc_scan_top #(
  parameter int              W  = 8,
  parameter int              N  = 8,
  parameter int              R  = 2,
  parameter psc_pkg::psc_op_e OP = psc_pkg::PSC_ADD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  output logic [N*W-1:0] out_data
);
  import psc_pkg::*;

  localparam int S = psc_stages(N, R);

  // Capture register
  logic                vld0_q;
  logic [N-1:0][W-1:0] own0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld0_q <= 1'b0;
    end else begin
      vld0_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own0_q <= '0;
    end else if (in_valid) begin
      own0_q <= in_data;
    end
  end

  // Pipeline: index 0 feeds the first switch stage
  logic [S:0]                vld;
  logic [S:0][N-1:0][W-1:0]  excl;
  logic [S:0][N-1:0][W-1:0]  tot;
  logic [S:0][N-1:0][W-1:0]  own;

  assign vld[0]  = vld0_q;
  assign excl[0] = '0;
  assign tot[0]  = own0_q;
  assign own[0]  = own0_q;

  genvar s, i;
  generate
    for (s = 0; s < S; s++) begin : g_stage
      psc_stage #(.W(W), .N(N), .R(R), .S_IDX(s), .OP(OP)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (vld[s]),
        .excl_i(excl[s]),
        .tot_i (tot[s]),
        .own_i (own[s]),
        .vld_o (vld[s+1]),
        .excl_o(excl[s+1]),
        .tot_o (tot[s+1]),
        .own_o (own[s+1])
      );
    end
  endgenerate

  // Final per-lane combine: exclusive prefix on the left, own value on the right
  logic [N-1:0][W-1:0] res_n;

  generate
    for (i = 0; i < N; i++) begin : g_final
      psc_op #(.W(W), .OP(OP)) u_fin (
        .a(excl[S][i]),
        .b(own[S][i]),
        .y(res_n[i])
      );
    end
  endgenerate

  logic                out_vld_q;
  logic [N-1:0][W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= vld[S];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (vld[S]) begin
      out_q <= res_n;
    end
  end

  assign out_valid = out_vld_q;
  assign out_data  = out_q;

  // ---------------- assertions ----------------

  // Lane 0 passes its own input through (R2)
  p_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_q[0] == $past(own[S][0])));

  // Top lane equals the block total carried by the network (R1)
  p_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_q[N-1] == $past(tot[S][N-1])));

  // Output held when no new result arrives (R7)
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld[S] |=> $stable(out_q));

  // Neighbouring lanes differ by exactly one operator step (R1, R3)
  generate
    for (i = 1; i < N; i++) begin : g_chk
      if (OP == PSC_ADD) begin : g_a
        p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (out_q[i] == W'(out_q[i-1] + $past(own[S][i]))));
      end else if (OP == PSC_MAX) begin : g_m
        p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> ((out_q[i] >= out_q[i-1]) &&
                         (out_q[i] >= $past(own[S][i]))));
      end else if (OP == PSC_OR) begin : g_o
        p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (out_q[i] == (out_q[i-1] | $past(own[S][i]))));
      end else begin : g_x
        p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (out_q[i] == (out_q[i-1] ^ $past(own[S][i]))));
      end
    end
  endgenerate

endmodule

// File: tb/tb_psc_scan_top.sv
`timescale 1ns/1ps
module tb_psc_scan_top;
  import psc_pkg::*;

  localparam int W  = 8;
  localparam int N  = 8;
  localparam int R  = 2;
  localparam int S  = 3;          // log_R(N)
  localparam int NV = 8;

  localparam logic [N*W-1:0] VEC [NV] = '{
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0706_0504_0302_0100,
    64'h8040_2010_0804_0201,
    64'hDEAD_BEEF_CAFE_F00D,
    64'h0123_4567_89AB_CDEF,
    64'hFF00_FF00_FF00_FF00,
    64'h1357_9BDF_2468_ACE0
  };

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [N*W-1:0] in_data;
  logic [3:0]           ov;
  logic [3:0][N*W-1:0]  od;

  int checks;
  int errors;

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  psc_scan_top #(.W(W), .N(N), .R(R), .OP(PSC_ADD)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov[0]), .out_data(od[0]));
  psc_scan_top #(.W(W), .N(N), .R(R), .OP(PSC_MAX)) dut_max (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov[1]), .out_data(od[1]));
  psc_scan_top #(.W(W), .N(N), .R(R), .OP(PSC_OR)) dut_or (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov[2]), .out_data(od[2]));
  psc_scan_top #(.W(W), .N(N), .R(R), .OP(PSC_XOR)) dut_xor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov[3]), .out_data(od[3]));

  function automatic logic [W-1:0] fop(input int op, input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    case (op)
      0:       return a + b;
      1:       return (a > b) ? a : b;
      2:       return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [N*W-1:0] ref_scan(input int op, input logic [N*W-1:0] v);
    logic [N*W-1:0] r;
    logic [W-1:0]   acc;
    acc = v[W-1:0];
    r[W-1:0] = acc;
    for (int i = 1; i < N; i++) begin
      acc = fop(op, acc, v[i*W +: W]);
      r[i*W +: W] = acc;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [N*W-1:0] act,
                     input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Present a vector for one cycle, then noise with in_valid low (R7)
  task automatic launch(input logic [N*W-1:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~v ^ 64'h5A5A_A5A5_3C3C_C3C3;
  endtask

  logic [3:0][N*W-1:0] last;

  // Launch, wait for the result cycle and check all operators (R1, R3, R5)
  task automatic run_vec(input logic [N*W-1:0] v, input string req);
    launch(v);
    repeat (S + 1) @(posedge clk);
    #1;
    for (int op = 0; op < 4; op++) begin
      chk({req, " valid"}, {63'd0, ov[op]}, 64'd1);
      chk(req, od[op], ref_scan(op, v));
      last[op] = od[op];
    end
    @(posedge clk);
    #1;
    chk("R5 single pulse", {60'd0, ov}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    logic [N*W-1:0] a;
    logic [N*W-1:0] b;
    logic [3:0][N*W-1:0] held;
    checks   = 0;
    errors   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk("R8 reset valid", {60'd0, ov}, 64'd0);
    for (int op = 0; op < 4; op++) chk("R8 reset data", od[op], 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk (R1, R3, R4, R5)
    for (int t = 0; t < NV; t++) begin
      run_vec(VEC[t], "R1 table");
      for (int op = 0; op < 4; op++)
        chk("R2 lane0", {56'd0, last[op][W-1:0]}, {56'd0, VEC[t][W-1:0]});
    end

    // R4 wrap on all-ones addition
    run_vec(64'hFFFF_FFFF_FFFF_FFFF, "R4 all ones");
    chk("R4 lane1 wrap", {56'd0, last[0][15:8]}, 64'hFE);
    chk("R4 lane7 wrap", {56'd0, last[0][63:56]}, 64'hF8);

    // R7 hold: idle cycles with input noise, outputs unchanged
    held = od;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_data = {2{$urandom()}};
    end
    #1;
    chk("R7 hold valid", {60'd0, ov}, 64'd0);
    for (int op = 0; op < 4; op++) chk("R7 hold data", od[op], held[op]);

    // R6 back-to-back vectors
    @(negedge clk);
    in_valid = 1'b1; in_data = VEC[2];
    @(negedge clk);
    in_data = VEC[4];
    @(negedge clk);
    in_data = VEC[7];
    @(negedge clk);
    in_valid = 1'b0; in_data = '1;
    // first vector sampled at the posedge before the second negedge above
    repeat (S - 1) @(posedge clk);
    #1;
    chk("R6 b2b first", od[0], ref_scan(0, VEC[2]));
    chk("R6 b2b first v", {63'd0, ov[0]}, 64'd1);
    @(posedge clk); #1;
    chk("R6 b2b second", od[1], ref_scan(1, VEC[4]));
    chk("R6 b2b second v", {63'd0, ov[1]}, 64'd1);
    @(posedge clk); #1;
    chk("R6 b2b third", od[3], ref_scan(3, VEC[7]));
    chk("R6 b2b third v", {63'd0, ov[3]}, 64'd1);
    @(posedge clk); #1;
    chk("R6 b2b end", {60'd0, ov}, 64'd0);

    // R9 top lane only changes top result lane
    a = 64'h1122_3344_5566_7788;
    b = {8'h0F, a[55:0]};
    run_vec(a, "R9 base");
    held = last;
    run_vec(b, "R9 changed");
    for (int op = 0; op < 4; op++)
      chk("R9 lower lanes", {8'd0, last[op][55:0]}, {8'd0, held[op][55:0]});

    // R8 reset during flight: no result appears
    launch(VEC[5]);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    begin
      logic seen;
      seen = 1'b0;
      for (int c = 0; c < S + 3; c++) begin
        @(posedge clk); #1;
        if (ov != 4'd0) seen = 1'b1;
      end
      chk("R8 flush no result", {63'd0, seen}, 64'd0);
    end
    for (int op = 0; op < 4; op++) chk("R8 flush data", od[op], 64'd0);

    summary();
    $finish;
  end

endmodule